// File: doc/BRIEF.md
# Clause-22 Management Master with Single Control Word

This block drives one management transaction at a time onto an MDC clock pin and a split MDIO data pin (output, output enable, input). Software sees a single 32-bit control word. Writing it with both the start flag and the enable flag set launches a read or write frame to the addressed PHY register. Software then polls the start flag, which doubles as a busy indication and drops by itself when the frame is over.

On a read, the 16 bits returned by the PHY overwrite the low half of the same word, so the result is fetched from where the request was placed. MDC is derived from the system clock by an even divider `CLK_DIV`, which must be at least 4. PHY addresses at or above `NUM_PHYS` are refused without any bus activity. Control and status pins are plain level signals. There is no streaming interface and no back-pressure.

Top module: `mdio_ctrl_master`

## Requirements
- R1: After reset the control word reads 0, MDC is low and the MDIO output enable is low.
- R2: The control word layout is as follows. Bits [15:0] hold write data or read result, [20:16] the register address and [25:21] the PHY address. Bit 27 = 1 selects read and 0 selects write. Bit 30 is enable and bit 31 is busy. A write with bits 31 and 30 both 1 and a PHY address below `NUM_PHYS` is stored as written, and bit 31 reads 1 from the next cycle.
- R3: A write that does not have both bits 31 and 30 set is stored with bit 31 forced to 0, and MDC does not toggle.
- R4: A start request whose PHY address is `NUM_PHYS` or more leaves bit 31 at 0 and produces no MDC edge. A refused read sets bits [15:0] to 0xFFFF. A refused write keeps the written data.
- R5: A started frame holds bit 31 at 1 for exactly 64*`CLK_DIV` clock cycles, after which it reads 0.
- R6: Each bit slot lasts `CLK_DIV` cycles. MDC is low for the first `CLK_DIV`/2 cycles and high for the rest. MDC is low whenever no frame is running.
- R7: The bits seen at MDC rising edges for a write, MSB first, are as follows. First come 32 ones, then 01, then opcode 01, then the PHY address, then the register address, then turnaround 10, then the 16 data bits. The output enable is high for all 64 slots.
- R8: A read frame sends opcode 10. The output enable drops for the last 18 slots. The 16 bits sampled from MDIO at the rising MDC edges of the last 16 slots, MSB first, land in bits [15:0] when bit 31 clears. Bits [30:16] keep their written value.
- R9: Writes to the control word while bit 31 is 1 are ignored, both in the stored value and on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Value to write into the control word |
| cfg_rd_data | output | 32 | Current control word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pin |

## Verification
The frame path is exercised with a mix of writes and reads. These use PHY and register addresses at zero, at all ones and in between, with write data of alternating, all-one and single-bit patterns. This separates errors in field order and bit order from errors in opcode and turnaround. Reads return patterns with distinct MSB and LSB, so a reversed or shifted capture shows up. Directed cases set the start flags only partly and use out-of-range PHY addresses for both reads and writes. A further case writes during a busy frame and checks that neither the stored word nor the bits on the wire change.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int TA_SLOT    = 46;
  localparam int DATA_SLOT  = 48;
  localparam int BUSY_BIT   = 31;
  localparam int ENA_BIT    = 30;
  localparam int READ_BIT   = 27;
  localparam int PHY_LSB    = 21;
  localparam int REG_LSB    = 16;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wdata
  );
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wdata)};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic slot_end
);
  localparam int CW = $clog2(CLK_DIV);
  localparam logic [CW-1:0] LAST    = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HALF    = CW'(CLK_DIV / 2);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLK_DIV / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  assign rise_stb = run && (cnt_q == HALF_M1);
  assign slot_end = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (run) begin
      cnt_q <= cnt_nxt;
      mdc   <= (cnt_nxt >= HALF);
    end else begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end
  end

  assert_slot_ends_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> mdc);
  assert_rise_from_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_read,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic                 rise_stb,
  input  logic                 slot_end,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rx_data
);
  localparam int IW = $clog2(FRAME_LEN);
  localparam logic [IW-1:0] LAST_SLOT = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] TA_IDX    = IW'(TA_SLOT);
  localparam logic [IW-1:0] DATA_IDX  = IW'(DATA_SLOT);

  logic                 rd_q;
  logic [IW-1:0]        idx_q;
  logic [FRAME_LEN-1:0] sh_q;

  assign done    = active && slot_end && (idx_q == LAST_SLOT);
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = active && !(rd_q && (idx_q >= TA_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      rx_data <= '0;
    end else if (start) begin
      active  <= 1'b1;
      rd_q    <= start_read;
      idx_q   <= '0;
      sh_q    <= frame_in;
      rx_data <= '0;
    end else if (active) begin
      if (rise_stb && rd_q && (idx_q >= DATA_IDX))
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      if (slot_end) begin
        sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_SLOT) active <= 1'b0;
      end
    end
  end

  assert_done_ends_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);
  assert_oe_only_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $rose(active));
endmodule

// File: rtl/mdio_ctrl_master.sv
module mdio_ctrl_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int NUM_PHYS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [ADDR_W:0] PHY_LIMIT = (ADDR_W+1)'(NUM_PHYS);

  logic [31:0]          ctrl_q;
  logic                 busy;
  logic                 accept;
  logic                 go;
  logic                 phy_ok;
  logic                 start;
  logic                 eng_active;
  logic                 eng_done;
  logic                 rise_stb;
  logic                 slot_end;
  logic [DATA_W-1:0]    rx_data;
  logic [FRAME_LEN-1:0] frame;

  assign busy   = ctrl_q[BUSY_BIT];
  assign accept = cfg_wr_en && !busy;
  assign go     = cfg_wr_data[BUSY_BIT] && cfg_wr_data[ENA_BIT];
  assign phy_ok = {1'b0, cfg_wr_data[PHY_LSB +: ADDR_W]} < PHY_LIMIT;
  assign start  = accept && go && phy_ok;
  assign frame  = build_frame(cfg_wr_data[READ_BIT], cfg_wr_data[PHY_LSB +: ADDR_W],
                              cfg_wr_data[REG_LSB +: ADDR_W], cfg_wr_data[DATA_W-1:0]);
  assign cfg_rd_data = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (accept) begin
      if (go && phy_ok)
        ctrl_q <= cfg_wr_data;
      else if (go)
        ctrl_q <= {1'b0, cfg_wr_data[30:16],
                   (cfg_wr_data[READ_BIT] ? 16'hFFFF : cfg_wr_data[15:0])};
      else
        ctrl_q <= {1'b0, cfg_wr_data[30:0]};
    end else if (eng_done) begin
      ctrl_q[BUSY_BIT] <= 1'b0;
      if (ctrl_q[READ_BIT]) ctrl_q[DATA_W-1:0] <= rx_data;
    end
  end

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) clk_gen_i (
    .clk(clk), .rst_n(rst_n), .run(eng_active),
    .mdc(mdc), .rise_stb(rise_stb), .slot_end(slot_end)
  );

  mdio_shift_engine engine_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_read(cfg_wr_data[READ_BIT]),
    .frame_in(frame), .rise_stb(rise_stb), .slot_end(slot_end), .mdio_i(mdio_i),
    .active(eng_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(eng_done),
    .rx_data(rx_data)
  );

  assert_busy_matches_engine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy == eng_active);
  assert_idle_mdc_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_ignore_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && busy && !eng_done) |=> (ctrl_q == $past(ctrl_q)));
  assert_refuse_bad_phy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && go && !phy_ok) |=> !busy);
  assert_partial_flags_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !go) |=> !busy);
endmodule

// File: tb/mdio_ctrl_master_tb_top.sv
module mdio_ctrl_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NPHY       = 5;
  localparam int FRAME_CYC  = 64 * DIV;
  localparam int NVEC       = 6;
  // vector: {rd, phy[4:0], reg[4:0], wdata[15:0], resp[15:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  5'd0,  16'hA5A5, 16'h0000},
    {1'b0, 5'd4,  5'd31, 16'h0001, 16'h0000},
    {1'b0, 5'd2,  5'd10, 16'hFFFF, 16'h0000},
    {1'b1, 5'd1,  5'd2,  16'h0000, 16'h1234},
    {1'b1, 5'd3,  5'd17, 16'h0000, 16'h8001},
    {1'b1, 5'd4,  5'd31, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          rise_cnt = 0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe = '0;
  logic [15:0] resp_cur = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_ctrl_master #(.CLK_DIV(DIV), .NUM_PHYS(NPHY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY responder: drives read data for slots 48..63, MSB first
  always_comb begin
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = resp_cur[63 - rise_cnt];
    else mdio_i = 1'b1;
  end

  always @(posedge mdc) begin
    cap_bits = {cap_bits[62:0], mdio_o};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    rise_cnt = rise_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = w;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int n, output int hi);
    n = 0; hi = 0;
    while (cfg_rd_data[31] && n < 4000) begin
      if (mdc) hi++;
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n, hi;
    logic [31:0] w, w2;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl", {32'd0, cfg_rd_data}, 64'd0);
    check("R1 mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic rd; logic [4:0] phy, rg; logic [15:0] d, r;
      {rd, phy, rg, d, r} = VEC[v];
      resp_cur = r; rise_cnt = 0; cap_bits = '0; cap_oe = '0;
      w = {2'b11, 2'b00, rd, 1'b0, phy, rg, d};
      write_word(w);
      check("R2 started word", {32'd0, cfg_rd_data}, {32'd0, w});
      wait_idle(n, hi);
      check("R5 busy length", 64'(n), 64'(FRAME_CYC));
      check("R6 mdc high cycles", 64'(hi), 64'(FRAME_CYC / 2));
      check("R6 slot count", 64'(rise_cnt), 64'd64);
      if (!rd) begin
        check("R7 write frame", cap_bits, exp_frame(1'b0, phy, rg, d));
        check("R7 oe all slots", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R2 final word", {32'd0, cfg_rd_data}, {32'd0, 1'b0, w[30:0]});
      end else begin
        check("R8 read header", {18'd0, cap_bits[63:18]},
              {18'd0, exp_frame(1'b1, phy, rg, 16'h0)} >> 18);
        check("R8 oe released", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
        check("R8 read result", {32'd0, cfg_rd_data}, {32'd0, 1'b0, w[30:16], r});
      end
      check("R6 idle mdc", {63'd0, mdc}, 64'd0);
    end

    // R3: partial start flags
    rise_cnt = 0;
    write_word(32'h4000_1234);
    check("R3 enable only", {32'd0, cfg_rd_data}, 64'h4000_1234);
    write_word(32'h8820_5678);
    check("R3 busy only", {32'd0, cfg_rd_data}, 64'h0820_5678);
    repeat (40) @(negedge clk);
    check("R3 no mdc", 64'(rise_cnt), 64'd0);

    // R4: out-of-range PHY addresses
    w = {2'b11, 2'b00, 1'b1, 1'b0, 5'd7, 5'd4, 16'h0042};
    write_word(w);
    check("R4 refused read", {32'd0, cfg_rd_data}, {32'd0, 1'b0, w[30:16], 16'hFFFF});
    w = {2'b11, 2'b00, 1'b0, 1'b0, 5'd31, 5'd9, 16'hBEEF};
    write_word(w);
    check("R4 refused write", {32'd0, cfg_rd_data}, {32'd0, 1'b0, w[30:0]});
    w = {2'b11, 2'b00, 1'b0, 1'b0, 5'd5, 5'd0, 16'h0001};
    write_word(w);
    check("R4 limit phy", {63'd0, cfg_rd_data[31]}, 64'd0);
    repeat (40) @(negedge clk);
    check("R4 no mdc", 64'(rise_cnt), 64'd0);

    // R9: write while busy
    rise_cnt = 0; cap_bits = '0; resp_cur = 16'h5555;
    w  = {2'b11, 2'b00, 1'b0, 1'b0, 5'd1, 5'd3, 16'h1111};
    w2 = {2'b11, 2'b00, 1'b1, 1'b0, 5'd2, 5'd6, 16'h2222};
    write_word(w);
    repeat (10) @(negedge clk);
    write_word(w2);
    check("R9 word held", {32'd0, cfg_rd_data}, {32'd0, w});
    wait_idle(n, hi);
    check("R9 final word", {32'd0, cfg_rd_data}, {32'd0, 1'b0, w[30:0]});
    check("R9 frame intact", cap_bits, exp_frame(1'b0, 5'd1, 5'd3, 16'h1111));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule